// File: doc/BRIEF.md
# Station Address Register and Destination Filter

This block holds a 48-bit station address. A bus in its own clock domain writes it as two 32-bit words. The block carries the address safely into a receive clock domain, where it is compared with the destination address of each incoming frame.

On the bus side there are two words:
- The upper word holds address bits 47:32 in its low half. Its top bit is a flag that always reads as one.
- The lower word holds address bits 31:0.

Bus writes land in a holding copy. The receive domain takes a new copy only when a low-word write touches the commit byte lane. That lane is the top lane (bits 31:24) in little-endian mode and the bottom lane (bits 7:0) in big-endian mode. The commit is carried across by a toggle signal. A two-flop synchronizer resynchronises it, and the receive side captures the whole 48-bit holding value on the toggle edge it detects. Two writes to the low word must be spaced at least four receive cycles apart.

On the receive side, the destination address arrives one byte per valid strobe, starting after a frame-start pulse. The first byte is compared with address bits 7:0 and each later byte with the next higher byte. A one-cycle match pulse follows the sixth byte when all six bytes were equal.

Top module: `sta_addr_filter`

## Requirements
- R1: After reset, the high word reads 0x8000FFFF, the low word reads 0xFFFFFFFF, the receive-domain address is all ones, and the match output is low.
- R2: A high-word write updates address bits 47:32 from byte lanes 0 and 1, gated by their strobes. Read bit 31 is always 1 and read bits 30:16 are always 0, whatever data is written.
- R3: A low-word write updates address bits 31:0, one byte lane per set strobe bit. The new value reads back at once from the holding copy.
- R4: With cfg_big_endian=0, a commit to the receive domain starts only on a low-word write whose strobe bit 3 (data bits 31:24) is set.
- R5: With cfg_big_endian=1, a commit starts only on a low-word write whose strobe bit 0 (data bits 7:0) is set.
- R6: A high-word write, or a low-word write without the commit lane, leaves the receive-domain address unchanged.
- R7: After a commit write, the receive-domain address equals the complete 48-bit holding value within 4 receive clock cycles.
- R8: Destination bytes are compared least-significant byte first. The received sequence 11,22,33,44,55,66 matches the stored address 0x665544332211, and the reverse order does not.
- R9: rx_match is high for exactly one cycle, the cycle after the sixth byte is accepted, and only if all six bytes equalled the stored address. A mismatch in any single position suppresses it.
- R10: rx_sof restarts the byte count and clears any partial result. A byte presented together with rx_sof counts as the first byte. Bytes received after the sixth byte, or with no preceding rx_sof since reset, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus-domain active-low reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_sel | input | 1 | Word select, 1 = high word, 0 = low word |
| bus_wr_data | input | 32 | Write data |
| bus_wr_strb | input | 4 | Byte-lane write enables |
| cfg_big_endian | input | 1 | Selects the commit lane (0: lane 3, 1: lane 0) |
| bus_rd_sel | input | 1 | Read word select, 1 = high word |
| bus_rd_data | output | 32 | Read data of the selected word |
| rx_clk | input | 1 | Receive clock |
| rx_rst_n | input | 1 | Receive-domain active-low reset |
| rx_sof | input | 1 | Frame-start pulse |
| rx_byte_vld | input | 1 | Destination byte valid |
| rx_byte | input | 8 | Destination byte |
| rx_station_addr | output | 48 | Address copy in the receive domain |
| rx_match | output | 1 | One-cycle destination match pulse |

## Verification
The destination comparison is driven from a vector table. The table holds:
- the exact address, which must give a match;
- six frames that each corrupt one byte position, which show that every lane of the comparator takes part;
- the byte-reversed address, which separates least-significant-first ordering from most-significant-first.

Directed sequences then cover the framing rules: bytes with no frame start, extra trailing bytes, a frame restarted part-way through, and a first byte that arrives together with the frame-start pulse. For the commit path, writes are made with and without the trigger lane in both endian modes. The receive copy is then sampled three receive edges later, which separates a correct two-flop handoff from a missing or extra stage. A trigger taken from the wrong lane also shows up here.

// File: rtl/sta_pkg.sv
package sta_pkg;
    localparam int ADDR_W   = 48;
    localparam int BUS_W    = 32;
    localparam int BYTE_W   = 8;
    localparam int N_BYTES  = ADDR_W / BYTE_W;
    localparam int HI_W     = ADDR_W - BUS_W;
    localparam int LANES    = BUS_W / BYTE_W;
    localparam int HI_LANES = HI_W / BYTE_W;
    localparam int CNT_W    = $clog2(N_BYTES + 1);

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [BUS_W-1:0] lo;
        logic             tgl;
    } bus_state_t;

    typedef struct packed {
        logic              s1;
        logic              s2;
        logic              seen;
        logic [ADDR_W-1:0] addr;
    } cdc_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ok;
        logic             match;
    } match_state_t;
endpackage

// File: rtl/sta_bus_regs.sv
module sta_bus_regs
    import sta_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [LANES-1:0]  wr_strb,
    input  logic              big_endian,
    input  logic              rd_sel,
    output logic [BUS_W-1:0]  rd_data,
    output logic [ADDR_W-1:0] hold_addr,
    output logic              commit_tgl
);
    localparam int RSVD_W = BUS_W - 1 - HI_W;

    bus_state_t st_d, st_q;
    logic       trig_hit;

    always_comb begin
        trig_hit = big_endian ? wr_strb[0] : wr_strb[LANES-1];
        st_d     = st_q;
        if (wr_en) begin
            if (wr_sel) begin
                for (int l = 0; l < HI_LANES; l++) begin
                    if (wr_strb[l]) st_d.hi[l*BYTE_W +: BYTE_W] = wr_data[l*BYTE_W +: BYTE_W];
                end
            end else begin
                for (int l = 0; l < LANES; l++) begin
                    if (wr_strb[l]) st_d.lo[l*BYTE_W +: BYTE_W] = wr_data[l*BYTE_W +: BYTE_W];
                end
                if (trig_hit) st_d.tgl = ~st_q.tgl;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hi  <= '1;
            st_q.lo  <= '1;
            st_q.tgl <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data    = rd_sel ? {1'b1, {RSVD_W{1'b0}}, st_q.hi} : st_q.lo;
    assign hold_addr  = {st_q.hi, st_q.lo};
    assign commit_tgl = st_q.tgl;

    AST_TGL_NEEDS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.tgl) |-> $past(wr_en && !wr_sel && (big_endian ? wr_strb[0] : wr_strb[LANES-1]))); // R4
    AST_HI_WRITE_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_sel) |-> $stable(st_q.tgl)); // R6
endmodule

// File: rtl/sta_cdc_capture.sv
module sta_cdc_capture
    import sta_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tgl_in,
    input  logic [ADDR_W-1:0] hold_addr,
    output logic [ADDR_W-1:0] rx_addr
);
    cdc_state_t cs_d, cs_q;
    logic       edge_det;

    always_comb begin
        edge_det     = cs_q.s2 ^ cs_q.seen;
        cs_d         = cs_q;
        cs_d.s1      = tgl_in;
        cs_d.s2      = cs_q.s1;
        cs_d.seen    = cs_q.s2;
        if (edge_det) cs_d.addr = hold_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q.s1   <= 1'b0;
            cs_q.s2   <= 1'b0;
            cs_q.seen <= 1'b0;
            cs_q.addr <= '1;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign rx_addr = cs_q.addr;

    AST_COPY_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_q.addr) |-> $past(edge_det)); // R6
    AST_EDGE_IS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_det |=> !edge_det); // R7
endmodule

// File: rtl/sta_da_match.sv
module sta_da_match
    import sta_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sof,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              match
);
    match_state_t ms_d, ms_q;
    logic [CNT_W-1:0]  idx;
    logic              ok_in;
    logic [BYTE_W-1:0] exp_byte;

    always_comb begin
        idx      = sof ? '0 : ms_q.cnt;
        ok_in    = sof ? 1'b1 : ms_q.ok;
        exp_byte = '0;
        for (int i = 0; i < N_BYTES; i++) begin
            if (idx == CNT_W'(i)) exp_byte = addr[i*BYTE_W +: BYTE_W];
        end
        ms_d       = ms_q;
        ms_d.match = 1'b0;
        if (sof) begin
            ms_d.cnt = '0;
            ms_d.ok  = 1'b1;
        end
        if (byte_vld && idx < CNT_W'(N_BYTES)) begin
            ms_d.cnt = idx + 1'b1;
            ms_d.ok  = ok_in && (byte_in == exp_byte);
            if (idx == CNT_W'(N_BYTES - 1)) ms_d.match = ok_in && (byte_in == exp_byte);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms_q.cnt   <= CNT_W'(N_BYTES);
            ms_q.ok    <= 1'b0;
            ms_q.match <= 1'b0;
        end else begin
            ms_q <= ms_d;
        end
    end

    assign match = ms_q.match;

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        ms_q.cnt <= CNT_W'(N_BYTES)); // R10
    AST_MATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> !match); // R9
    AST_MATCH_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> $past(byte_vld)); // R9
endmodule

// File: rtl/sta_addr_filter.sv
module sta_addr_filter
    import sta_pkg::*;
(
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_wr_sel,
    input  logic [BUS_W-1:0]  bus_wr_data,
    input  logic [LANES-1:0]  bus_wr_strb,
    input  logic              cfg_big_endian,
    input  logic              bus_rd_sel,
    output logic [BUS_W-1:0]  bus_rd_data,
    input  logic              rx_clk,
    input  logic              rx_rst_n,
    input  logic              rx_sof,
    input  logic              rx_byte_vld,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [ADDR_W-1:0] rx_station_addr,
    output logic              rx_match
);
    logic [ADDR_W-1:0] hold_addr;
    logic              commit_tgl;

    sta_bus_regs u_regs (
        .clk        (bus_clk),
        .rst_n      (bus_rst_n),
        .wr_en      (bus_wr_en),
        .wr_sel     (bus_wr_sel),
        .wr_data    (bus_wr_data),
        .wr_strb    (bus_wr_strb),
        .big_endian (cfg_big_endian),
        .rd_sel     (bus_rd_sel),
        .rd_data    (bus_rd_data),
        .hold_addr  (hold_addr),
        .commit_tgl (commit_tgl)
    );

    sta_cdc_capture u_cdc (
        .clk       (rx_clk),
        .rst_n     (rx_rst_n),
        .tgl_in    (commit_tgl),
        .hold_addr (hold_addr),
        .rx_addr   (rx_station_addr)
    );

    sta_da_match u_match (
        .clk      (rx_clk),
        .rst_n    (rx_rst_n),
        .addr     (rx_station_addr),
        .sof      (rx_sof),
        .byte_vld (rx_byte_vld),
        .byte_in  (rx_byte),
        .match    (rx_match)
    );
endmodule

// File: tb/sta_addr_filter_tb.sv
module sta_addr_filter_tb_top;
    logic        bus_clk = 1'b0, rx_clk = 1'b0;
    logic        bus_rst_n = 1'b0, rx_rst_n = 1'b0;
    logic        bus_wr_en = 1'b0, bus_wr_sel = 1'b0;
    logic [31:0] bus_wr_data = '0;
    logic [3:0]  bus_wr_strb = '0;
    logic        cfg_big_endian = 1'b0, bus_rd_sel = 1'b0;
    logic [31:0] bus_rd_data;
    logic        rx_sof = 1'b0, rx_byte_vld = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [47:0] rx_station_addr;
    logic        rx_match;

    int  errors = 0, checks = 0;
    bit  done = 1'b0;

    always #5 bus_clk = ~bus_clk;
    always #4 rx_clk  = ~rx_clk;

    sta_addr_filter dut_i (.*);

    // {expected match, frame with first byte in bits 7:0}
    localparam logic [48:0] VEC [8] = '{
        {1'b1, 48'h665544332211},
        {1'b0, 48'h665544332210},
        {1'b0, 48'h665544332311},
        {1'b0, 48'h665544322211},
        {1'b0, 48'h665545332211},
        {1'b0, 48'h665444332211},
        {1'b0, 48'hE65544332211},
        {1'b0, 48'h112233445566}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic sel, input logic [31:0] data, input logic [3:0] strb);
        @(negedge bus_clk);
        bus_wr_en = 1'b1; bus_wr_sel = sel; bus_wr_data = data; bus_wr_strb = strb;
        @(posedge bus_clk);
        @(negedge bus_clk);
        bus_wr_en = 1'b0; bus_wr_strb = '0;
    endtask

    task automatic bus_read(input logic sel, output logic [31:0] val);
        @(negedge bus_clk);
        bus_rd_sel = sel;
        #1 val = bus_rd_data;
    endtask

    task automatic rx_wait(input int n);
        for (int i = 0; i < n; i++) @(posedge rx_clk);
        #1;
    endtask

    // nbytes bytes of f, first byte first; optional sof before or on first byte
    task automatic send(input logic [47:0] f, input int nbytes, input bit do_sof,
                        input bit sof_on_first, output logic m1, output logic m2);
        @(negedge rx_clk);
        if (do_sof && !sof_on_first) begin
            rx_sof = 1'b1;
            @(negedge rx_clk);
            rx_sof = 1'b0;
        end
        for (int i = 0; i < nbytes; i++) begin
            rx_sof      = do_sof && sof_on_first && (i == 0);
            rx_byte_vld = 1'b1;
            rx_byte     = f[i*8 +: 8];
            @(negedge rx_clk);
        end
        rx_sof = 1'b0; rx_byte_vld = 1'b0;
        m1 = rx_match;
        @(negedge rx_clk);
        m2 = rx_match;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge bus_clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        logic m1, m2;
        repeat (3) @(posedge bus_clk);
        bus_rst_n = 1'b1; rx_rst_n = 1'b1;
        repeat (2) @(posedge bus_clk);

        // R1 reset state
        bus_read(1'b1, rd); check("R1 high word", 64'(rd), 64'h8000FFFF);
        bus_read(1'b0, rd); check("R1 low word", 64'(rd), 64'hFFFFFFFF);
        check("R1 rx copy", 64'(rx_station_addr), 64'hFFFFFFFFFFFF);
        check("R1 match", 64'(rx_match), 64'h0);

        // R10 bytes without a preceding sof are ignored
        send(48'hFFFFFFFFFFFF, 6, 1'b0, 1'b0, m1, m2);
        check("R10 no sof no match", 64'(m1), 64'h0);

        // R2 / R6 high word write, no commit
        bus_write(1'b1, 32'h12346655, 4'b1111);
        bus_read(1'b1, rd); check("R2 high readback", 64'(rd), 64'h80006655);
        rx_wait(6); check("R6 high write no commit", 64'(rx_station_addr), 64'hFFFFFFFFFFFF);

        // R3 / R6 low write without trigger lane
        bus_write(1'b0, 32'h44332211, 4'b0111);
        bus_read(1'b0, rd); check("R3 low partial", 64'(rd), 64'hFF332211);
        rx_wait(6); check("R6 low no lane no commit", 64'(rx_station_addr), 64'hFFFFFFFFFFFF);

        // R4 / R7 little-endian commit on lane 3
        bus_write(1'b0, 32'h44000000, 4'b1000);
        rx_wait(3); check("R7 R4 commit in time", 64'(rx_station_addr), 64'h665544332211);
        bus_read(1'b0, rd); check("R3 low full", 64'(rd), 64'h44332211);

        // R8 / R9 vector table walk
        foreach (VEC[k]) begin
            send(VEC[k][47:0], 6, 1'b1, 1'b0, m1, m2);
            check($sformatf("R8 R9 vector %0d match", k), 64'(m1), 64'(VEC[k][48]));
            check($sformatf("R9 vector %0d pulse ends", k), 64'(m2), 64'h0);
        end

        // R10 bytes beyond six ignored
        send(48'h665544332211, 6, 1'b1, 1'b0, m1, m2);
        send(48'h665544332211, 6, 1'b0, 1'b0, m1, m2);
        check("R10 trailing bytes ignored", 64'(m1), 64'h0);

        // R10 restart mid-frame
        send(48'h000000000000, 3, 1'b1, 1'b0, m1, m2);
        send(48'h665544332211, 6, 1'b1, 1'b0, m1, m2);
        check("R10 restart then match", 64'(m1), 64'h1);

        // R10 sof on first byte
        send(48'h665544332211, 6, 1'b1, 1'b1, m1, m2);
        check("R10 sof with first byte", 64'(m1), 64'h1);

        // R5 big-endian: lane 3 no longer commits, lane 0 does
        cfg_big_endian = 1'b1;
        bus_write(1'b0, 32'hAABBCCDD, 4'b1110);
        rx_wait(6); check("R5 lane3 no commit in BE", 64'(rx_station_addr), 64'h665544332211);
        bus_write(1'b0, 32'h000000DD, 4'b0001);
        rx_wait(3); check("R5 R7 lane0 commit", 64'(rx_station_addr), 64'h6655AABBCCDD);
        send(48'h6655AABBCCDD, 6, 1'b1, 1'b0, m1, m2);
        check("R8 match new address", 64'(m1), 64'h1);

        done = 1'b1;
        finish_run();
    end
endmodule